// File: doc/BRIEF.md
# Serial Transmitter with Selectable Byte Queue

This block is the sending half of a classic asynchronous serial port. A host hands it bytes one at a time through a write strobe. Each byte waits in a holding stage until a shift stage sends it on a single output line. A frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. The line rests high between frames.

The holding stage has two modes, chosen by a mode input. In buffered mode it is a 16-deep first-in first-out queue. In direct mode it holds a single byte. Changing the mode, or pulsing the flush input, empties the holding stage. A frame already on the line still finishes.

Timing comes from an external strobe at sixteen times the bit rate. Each bit on the line lasts sixteen of these strobes. Two status outputs tell the host whether the holding stage is empty and whether the whole transmitter, shift stage included, has gone quiet.

Top module: `uart_txq`

## Requirements
- R1: After reset, and whenever `tx_empty` is high, `txd` is 1; just after reset `hold_empty` and `tx_empty` are both 1.
- R2: A frame is a 0 start bit, then the data bits with bit 0 first, then the parity bit if enabled, then the stop bits at 1. `cfg_wlen` sets the data length: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8.
- R3: Every bit after the start bit lasts exactly 16 pulses of `tick16`. `txd` only rises in the clock cycle right after a `tick16` pulse.
- R4: With `cfg_par_en`=1, the parity bit covers only the configured data bits. With `cfg_par_odd`=0 the parity is even: the ones in the data plus the parity bit make an even count. With `cfg_par_odd`=1 that count is odd.
- R5: `cfg_stop2`=0 sends one stop bit and `cfg_stop2`=1 sends two.
- R6: With `fifo_en`=1, up to 16 written bytes wait in the queue and go out in write order.
- R7: With `fifo_en`=0, the holding stage keeps a single byte. A write while that byte is still waiting is dropped.
- R8: A write while the holding stage is full is dropped, and the bytes already queued are unchanged.
- R9: If the holding stage has data when the last stop bit ends, the next start bit begins at once, with no idle bit time between.
- R10: `hold_empty` is 1 exactly when the holding stage holds no byte.
- R11: `tx_empty` is 1 only when `hold_empty` is 1 and no frame is on the line.
- R12: A `fifo_clear` pulse, or any change of `fifo_en`, empties the holding stage in the next cycle. The frame being sent still completes, and the discarded bytes are never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| fifo_en | input | 1 | 1 = 16-deep queue, 0 = single-byte holding |
| fifo_clear | input | 1 | Flush pulse for the holding stage |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte written by the host |
| cfg_wlen | input | 2 | Data length code, 0..3 for 5..8 bits |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| cfg_par_en | input | 1 | 1 = append a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding stage is empty |
| tx_empty | output | 1 | Holding stage and shift stage are both empty |

## Verification
Two pairs of events can fall in the same clock cycle, and the bench provokes both.

The first pair is the end of the last stop bit and the move of the next waiting byte into the shift stage. The bench fills the queue with a burst and checks that the interval between successive start edges equals the frame length in clock cycles exactly.

The second pair is a flush, or a mode change, arriving while bytes wait and a frame is on the line. The bench expects the frame in flight to complete and nothing more to be sent. The scoreboard then reports any extra frame as unexpected.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       stop2;
        logic       par_en;
        logic       par_odd;
    } frame_cfg_t;

    localparam int unsigned BYTE_W = 8;

    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic [BYTE_W-1:0] width_mask(input logic [1:0] code);
        return 8'hFF >> (2'd3 - code);
    endfunction

    function automatic logic parity_bit(input logic [BYTE_W-1:0] data,
                                        input logic [1:0] code,
                                        input logic odd);
        return (^(data & width_mask(code))) ^ odd;
    endfunction

endpackage

// File: rtl/uart_txq_buf.sv
module uart_txq_buf #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              deep_mode,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              avail,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W-1:0] CAP_DEEP = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_ONE  = CNT_W'(1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              mode_q;
    logic              flush_all;
    logic              do_push, do_pop;
    logic [CNT_W-1:0]  cap;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign flush_all = flush || (deep_mode != mode_q);
    assign cap       = deep_mode ? CAP_DEEP : CAP_ONE;
    assign empty     = (count == '0);
    assign full      = (count >= cap);
    assign avail     = !empty && !flush_all;
    assign head_data = mem[rd_ptr];
    assign do_push   = push && !full && !flush_all;
    assign do_pop    = pop && avail;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            mode_q <= deep_mode;
        end else begin
            mode_q <= deep_mode;
            if (flush_all) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                count  <= '0;
            end else begin
                if (do_push) begin
                    wr_ptr <= ptr_next(wr_ptr);
                end
                if (do_pop) begin
                    rd_ptr <= ptr_next(rd_ptr);
                end
                case ({do_push, do_pop})
                    2'b10:   count <= count + 1'b1;
                    2'b01:   count <= count - 1'b1;
                    default: count <= count;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_txq_shift.sv
module uart_txq_shift
    import uart_txq_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16,
    localparam int unsigned TC_W = $clog2(OVERSAMPLE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              avail,
    input  logic [BYTE_W-1:0] din,
    input  frame_cfg_t        cfg,
    output logic              pull,
    output logic              txd,
    output logic              idle
);

    localparam logic [TC_W-1:0] TC_LAST = TC_W'(OVERSAMPLE - 1);

    tx_state_e         state;
    logic [TC_W-1:0]   tcnt;
    logic [2:0]        bidx;
    logic [BYTE_W-1:0] shreg;
    logic              parq;
    frame_cfg_t        cfg_q;
    logic              bit_end;
    logic              last_stop;
    logic              last_data;

    assign bit_end   = tick && (tcnt == TC_LAST);
    assign last_stop = (state == ST_STOP) && bit_end &&
                       (!cfg_q.stop2 || (bidx == 3'd1));
    assign last_data = ({1'b0, bidx} == (data_bits(cfg_q.wlen) - 4'd1));
    assign pull      = avail && ((state == ST_IDLE) || last_stop);
    assign idle      = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
            parq  <= 1'b0;
            cfg_q <= '0;
        end else if (pull) begin
            state <= ST_START;
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= din;
            parq  <= parity_bit(din, cfg.wlen, cfg.par_odd);
            cfg_q <= cfg;
        end else begin
            if ((state != ST_IDLE) && tick) begin
                tcnt <= tcnt + 1'b1;
            end
            if (bit_end) begin
                case (state)
                    ST_START: begin
                        state <= ST_DATA;
                        bidx  <= '0;
                    end
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if (last_data) begin
                            state <= cfg_q.par_en ? ST_PAR : ST_STOP;
                            bidx  <= '0;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        state <= ST_STOP;
                        bidx  <= '0;
                    end
                    ST_STOP: begin
                        if (last_stop) begin
                            state <= ST_IDLE;
                        end else begin
                            bidx <= 3'd1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = parq;
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_txq.sv
module uart_txq
    import uart_txq_pkg::*;
#(
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       fifo_en,
    input  logic       fifo_clear,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_stop2,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_empty
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = PTR_W + 1;

    frame_cfg_t        cfg;
    logic [BYTE_W-1:0] head_data;
    logic              buf_avail, buf_empty, buf_full;
    logic [CNT_W-1:0]  buf_count;
    logic              pull, sh_idle;

    assign cfg = '{wlen: cfg_wlen, stop2: cfg_stop2,
                   par_en: cfg_par_en, par_odd: cfg_par_odd};

    uart_txq_buf #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) buf_i (
        .clk       (clk),
        .rst       (rst),
        .deep_mode (fifo_en),
        .flush     (fifo_clear),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pull),
        .head_data (head_data),
        .avail     (buf_avail),
        .empty     (buf_empty),
        .full      (buf_full),
        .count     (buf_count)
    );

    uart_txq_shift #(.OVERSAMPLE(OVERSAMPLE)) shift_i (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick16),
        .avail (buf_avail),
        .din   (head_data),
        .cfg   (cfg),
        .pull  (pull),
        .txd   (txd),
        .idle  (sh_idle)
    );

    assign hold_empty = buf_empty;
    assign tx_empty   = buf_empty && sh_idle;

endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             tick16,
    input logic             wr_en,
    input logic             fifo_clear,
    input logic             txd,
    input logic             hold_empty,
    input logic             tx_empty,
    input logic             buf_full,
    input logic [CNT_W-1:0] buf_count
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> txd);  // R1

    AST_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        !$past(tick16) |-> !$rose(txd));  // R3

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        buf_count <= CNT_W'(DEPTH));  // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (buf_full && wr_en && !fifo_clear) |=> (buf_count <= $past(buf_count)));  // R8

    AST_EMPTY_FLAG_COUNT: assert property (@(posedge clk) disable iff (rst)
        hold_empty == (buf_count == '0));  // R10

    AST_TX_EMPTY_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> hold_empty);  // R11

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        fifo_clear |=> hold_empty);  // R12

endmodule

bind uart_txq uart_txq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .tick16     (tick16),
    .wr_en      (wr_en),
    .fifo_clear (fifo_clear),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty),
    .buf_full   (buf_full),
    .buf_count  (buf_count)
);

// File: tb/uart_txq_tb_top.sv
module uart_txq_tb_top;

    localparam int TDIV  = 4;
    localparam int BITC  = 16 * TDIV;
    localparam int LIMIT = 150000;

    typedef struct {
        logic [7:0] d;
        logic [1:0] wl;
        logic       s2;
        logic       pe;
        logic       po;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1, tick16 = 1'b0;
    logic fifo_en = 1'b0, fifo_clear = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cfg_wlen = 2'b11;
    logic cfg_stop2 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic txd, hold_empty, tx_empty;

    int n_checks = 0, n_fail = 0, cyc = 0, gapless = 0;
    exp_t sbq[$];

    uart_txq dut_i (
        .clk(clk), .rst(rst), .tick16(tick16), .fifo_en(fifo_en),
        .fifo_clear(fifo_clear), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_wlen(cfg_wlen), .cfg_stop2(cfg_stop2), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .txd(txd), .hold_empty(hold_empty),
        .tx_empty(tx_empty)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            repeat (TDIV - 1) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    task automatic send(input logic [7:0] d, input bit keep);
        exp_t e;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        if (keep) begin
            e.d = d; e.wl = cfg_wlen; e.s2 = cfg_stop2; e.pe = cfg_par_en; e.po = cfg_par_odd;
            sbq.push_back(e);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(tx_empty && sbq.size() == 0)) @(negedge clk);
        repeat (40) @(negedge clk);
        check(txd == 1'b1 && tx_empty, "R1 idle", txd, 1);
    endtask

    task automatic set_cfg(input logic [1:0] wl, input bit s2, input bit pe, input bit po);
        cfg_wlen = wl; cfg_stop2 = s2; cfg_par_en = pe; cfg_par_odd = po;
    endtask

    // Scoreboard monitor: recovers each frame from txd and compares.
    initial begin
        logic prev = 1'b1;
        int prev_start = 0, prev_len = 0;
        bit have_prev = 1'b0;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            @(negedge clk);
            if (prev && !txd) begin
                exp_t e;
                int nb, t0, len, ones;
                logic [7:0] got;
                logic pbit, s_a, s_b, exp_p;
                t0 = cyc;
                if (sbq.size() == 0) begin
                    check(1'b0, "R12 unexpected frame", 1, 0);
                    e.d = 0; e.wl = 3; e.s2 = 0; e.pe = 0; e.po = 0;
                end else begin
                    e = sbq.pop_front();
                end
                nb = 5 + int'(e.wl);
                len = 1 + nb + (e.pe ? 1 : 0) + (e.s2 ? 2 : 1);
                if (have_prev && (t0 - prev_start) == prev_len * BITC) gapless++;
                repeat (BITC / 2) @(negedge clk);
                check(txd == 1'b0, "R2 start bit", txd, 0);
                got = 8'h00;
                for (int i = 0; i < nb; i++) begin
                    repeat (BITC) @(negedge clk);
                    got[i] = txd;
                end
                pbit = 1'b0;
                if (e.pe) begin
                    repeat (BITC) @(negedge clk);
                    pbit = txd;
                end
                repeat (BITC) @(negedge clk);
                s_a = txd;
                s_b = 1'b1;
                if (e.s2) begin
                    repeat (BITC) @(negedge clk);
                    s_b = txd;
                end
                ones = 0;
                for (int i = 0; i < nb; i++) ones += int'(e.d[i]);
                exp_p = (ones % 2 == 1) ^ e.po;
                check(got == (e.d & (8'hFF >> (8 - nb))), "R2 R6 data", got, e.d);
                if (e.pe) check(pbit == exp_p, "R4 parity", pbit, exp_p);
                check(s_a && s_b, "R5 stop bits", {s_a, s_b}, 3);
                prev_start = t0;
                prev_len = len;
                have_prev = 1'b1;
                prev = txd;
            end else begin
                prev = txd;
            end
        end
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        check(1'b0, "watchdog", cyc, LIMIT);
        finish_up();
    end

    initial begin
        int g0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R1 reset txd", txd, 1);
        check(hold_empty && tx_empty, "R1 reset flags", {hold_empty, tx_empty}, 3);

        // Single frames under several formats (direct mode).
        set_cfg(2'b11, 0, 0, 0); send(8'hA5, 1); wait_idle();
        set_cfg(2'b00, 0, 1, 0); send(8'hF3, 1); wait_idle();   // R4 even, 5 bits
        set_cfg(2'b10, 1, 1, 1); send(8'hC6, 1); wait_idle();   // R4 odd, R5 two stops
        set_cfg(2'b01, 1, 0, 0); send(8'h2D, 1); wait_idle();
        set_cfg(2'b11, 1, 1, 0); send(8'h81, 1); wait_idle();
        set_cfg(2'b11, 0, 1, 1); send(8'h00, 1); wait_idle();

        // R7 R10 R11: single-byte holding, extra write dropped.
        set_cfg(2'b11, 0, 0, 0);
        send(8'h11, 1);
        repeat (3) @(negedge clk);
        check(hold_empty == 1'b1, "R10 empty after load", hold_empty, 1);
        check(tx_empty == 1'b0, "R11 busy shifter", tx_empty, 0);
        send(8'h22, 1);
        check(hold_empty == 1'b0, "R10 holding one byte", hold_empty, 0);
        send(8'h33, 0);
        wait_idle();

        // R6 R8 R9 R3: queue burst, overflow, back-to-back frames.
        fifo_en = 1'b1;
        repeat (3) @(negedge clk);
        g0 = gapless;
        send(8'h40, 1);
        repeat (3) @(negedge clk);
        for (int i = 1; i <= 16; i++) send(8'h40 + 8'(i), 1);
        send(8'hEE, 0);
        send(8'hEF, 0);
        check(hold_empty == 1'b0, "R10 queue full flag", hold_empty, 0);
        wait_idle();
        check(gapless - g0 >= 15, "R9 R3 gapless exact bit time", gapless - g0, 15);

        // R12: flush pulse mid-frame.
        send(8'h5A, 1);
        send(8'h5B, 0);
        send(8'h5C, 0);
        repeat (100) @(negedge clk);
        fifo_clear = 1'b1;
        @(negedge clk);
        fifo_clear = 1'b0;
        check(hold_empty == 1'b1, "R12 flush empties", hold_empty, 1);
        check(tx_empty == 1'b0, "R12 frame still running", tx_empty, 0);
        wait_idle();

        // R12: mode change mid-frame.
        send(8'h69, 1);
        send(8'h6A, 0);
        send(8'h6B, 0);
        repeat (100) @(negedge clk);
        fifo_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(hold_empty == 1'b1, "R12 mode change empties", hold_empty, 1);
        wait_idle();
        check(sbq.size() == 0, "R6 all frames seen", sbq.size(), 0);

        finish_up();
    end

endmodule